// File: doc/BRIEF.md
# Dual-Channel Compare-Match Timer

This peripheral holds two independent timer channels behind one small register bus. Channel 0 is the slow general-purpose channel, which is fed by a 32768 Hz tick enable. Channel 1 is the fast debug channel, which is fed by a 19.2 MHz tick enable; software usually discards the low 5 bits of its count to get a 600 kHz time base. Each channel has a free-running up-counter, a match register and a run-control register. Each channel also has a clear register that can only be written. Each channel drives its own expiry interrupt, a single-clock pulse that software treats as a rising edge. Both channels work in the one system clock domain and advance only on cycles where their own tick input is high.

Each channel keeps its run control as a four-state machine. The states are `ST_HALT` (stopped), `ST_FREE` (counting, wraps past the match), `ST_PARKED` (stopped, restart-on-match armed) and `ST_RELOAD` (counting, returns to zero on a match). A write to the control word with bits [1:0] = 00, 01, 10 or 11 takes the transition `to_halt`, `to_free`, `to_parked` or `to_reload`, in that order, from any state. Otherwise the state holds (`stay`). A shared protection bit blocks every write to both channel banks. The protection register itself stays writable.

Top module: `cmtimer_pair`

## Requirements
- R1: After reset each count reads 0, each control word reads 0, the protection register reads 0, both interrupts are low, and each match register reads all ones over the counter width (0xFFFFFFFF for 32 bits).
- R2: Byte address map. Channel 0 uses 0x00 for match (read/write), 0x04 for count (read-only, writes ignored), 0x08 for control bits [1:0] and 0x0C for clear (reads 0). Channel 1 uses the same offsets plus 0x10. Protection is at 0x20 and only bit 0 is stored. Every other address reads 0.
- R3: A running channel (control bit 0 = 1) adds one to its count on each clock where its tick input is high, and holds its count when the tick is low. The count wraps from all ones to zero.
- R4: Writing the control word with bit 0 = 0 stops counting and keeps the current count. The control word reads back the two bits written.
- R5: Any write to a clear register sets that channel's count to 0 at the next clock edge, whatever the data. The clear wins over a tick in the same cycle, and no interrupt comes from that cycle.
- R6: With bit 1 = 0, a tick that brings the count equal to the match value raises that channel's interrupt for exactly one clock, starting at the same edge. At that edge the count reads the match value.
- R7: With bit 1 = 1, the tick that would bring the count equal to the match value loads 0 instead and still pulses the interrupt. The period is therefore M ticks for a match value M.
- R8: While protection bit 0 is 1, writes to 0x00–0x1C have no effect. Reads still return live values, and the protection register can still be written.
- R9: The two channels are independent. Each uses only its own tick, registers and interrupt.
- R10: A free-running channel whose match is 0 interrupts on the tick that wraps the count from all ones to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gp_tick | input | 1 | Count enable for channel 0 |
| dbg_tick | input | 1 | Count enable for channel 1 |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| gp_irq | output | 1 | Channel 0 expiry pulse |
| dbg_irq | output | 1 | Channel 1 expiry pulse |

## Verification
The hardest case to reach is the counter wrap. With a 32-bit counter it needs four billion ticks, and no register can preload the count. The bench therefore runs a second instance with an 8-bit counter next to the default one, drives it 256 ticks and checks the wrap interrupt. The default instance at the same time must read 0x100. The second hard case is a clear that lands on the very tick that would have matched. The bench lines the count up one tick below the match and writes clear together with a tick, so it can show that the count goes to zero and that no interrupt comes from that cycle.

// File: rtl/cmtimer_pkg.sv
package cmtimer_pkg;

    // Control-word encoding: bit 0 runs the counter, bit 1 restarts on match.
    typedef enum logic [1:0] {
        ST_HALT   = 2'b00,
        ST_FREE   = 2'b01,
        ST_PARKED = 2'b10,
        ST_RELOAD = 2'b11
    } run_state_e;

    // Register slot inside one channel bank, from byte address bits [3:2].
    typedef enum logic [1:0] {
        REG_MATCH = 2'd0,
        REG_COUNT = 2'd1,
        REG_CTRL  = 2'd2,
        REG_CLEAR = 2'd3
    } reg_sel_e;

    localparam int BANK_STRIDE = 16;
    localparam int BANK_SH     = $clog2(BANK_STRIDE);

endpackage

// File: rtl/cmtimer_chan.sv
module cmtimer_chan
    import cmtimer_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              match_we,
    input  logic              ctrl_we,
    input  logic              clr_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] count_o,
    output logic [DATA_W-1:0] match_o,
    output logic [1:0]        ctrl_o,
    output logic              irq_o
);

    run_state_e       state_q, state_d;
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] match_q;
    logic [CNT_W-1:0] cnt_inc;
    logic             running;
    logic             restart;
    logic             hit;
    logic             irq_q;

    // Next-state: a control write jumps straight to the written mode.
    always_comb begin
        state_d = state_q;
        if (ctrl_we) begin
            unique case (wdata[1:0])
                2'b00: state_d = ST_HALT;
                2'b01: state_d = ST_FREE;
                2'b10: state_d = ST_PARKED;
                2'b11: state_d = ST_RELOAD;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    assign running = (state_q == ST_FREE) || (state_q == ST_RELOAD);
    assign restart = (state_q == ST_RELOAD);
    assign cnt_inc = count_q + 1'b1;
    assign hit     = running && tick && (cnt_inc == match_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                count_q <= '0;
        else if (clr_we)           count_q <= '0;
        else if (running && tick)  count_q <= (hit && restart) ? '0 : cnt_inc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        match_q <= '1;
        else if (match_we) match_q <= wdata[CNT_W-1:0];
    end

    // Output process: registered expiry pulse.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= hit && !clr_we;
    end

    assign count_o = DATA_W'(count_q);
    assign match_o = DATA_W'(match_q);
    assign ctrl_o  = state_q;
    assign irq_o   = irq_q;

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> (count_q == '0)); // R5

    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !clr_we) |=> $stable(count_q)); // R4

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FREE && tick && !clr_we) |=> (count_q == $past(count_q) + 1'b1)); // R3

    AST_IRQ_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> ($past(tick) && ($past(state_q) == ST_FREE || $past(state_q) == ST_RELOAD))); // R6

    AST_FREE_AT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && $past(state_q) == ST_FREE) |-> (count_q == $past(match_q))); // R6

    AST_RELOAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && $past(state_q) == ST_RELOAD) |-> (count_q == '0)); // R7

endmodule

// File: rtl/cmtimer_decode.sv
module cmtimer_decode
    import cmtimer_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32,
    parameter int NUM_CH = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic                           bus_wr,
    input  logic                           prot_wbit,
    input  logic [NUM_CH-1:0][DATA_W-1:0]  ch_count,
    input  logic [NUM_CH-1:0][DATA_W-1:0]  ch_match,
    input  logic [NUM_CH-1:0][1:0]         ch_ctrl,
    output logic [NUM_CH-1:0]              match_we,
    output logic [NUM_CH-1:0]              ctrl_we,
    output logic [NUM_CH-1:0]              clr_we,
    output logic [DATA_W-1:0]              bus_rdata
);

    localparam int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int PROT_ADDR = NUM_CH * BANK_STRIDE;

    logic            prot_q;
    logic            aligned;
    logic            bank_hit;
    logic            prot_hit;
    logic [CH_W-1:0] ch_idx;
    reg_sel_e        rsel;

    assign aligned  = (bus_addr[1:0] == 2'b00);
    assign bank_hit = aligned && (int'(bus_addr) < PROT_ADDR);
    assign prot_hit = (int'(bus_addr) == PROT_ADDR);
    assign ch_idx   = bus_addr[BANK_SH +: CH_W];
    assign rsel     = reg_sel_e'(bus_addr[3:2]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 prot_q <= 1'b0;
        else if (bus_wr && prot_hit) prot_q <= prot_wbit;
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_we
        logic sel;
        assign sel         = bus_wr && bank_hit && !prot_q && (ch_idx == CH_W'(c));
        assign match_we[c] = sel && (rsel == REG_MATCH);
        assign ctrl_we[c]  = sel && (rsel == REG_CTRL);
        assign clr_we[c]   = sel && (rsel == REG_CLEAR);
    end

    always_comb begin
        bus_rdata = '0;
        if (prot_hit) begin
            bus_rdata = DATA_W'(prot_q);
        end else if (bank_hit) begin
            unique case (rsel)
                REG_MATCH: bus_rdata = ch_match[ch_idx];
                REG_COUNT: bus_rdata = ch_count[ch_idx];
                REG_CTRL:  bus_rdata = DATA_W'(ch_ctrl[ch_idx]);
                REG_CLEAR: bus_rdata = '0;
            endcase
        end
    end

    AST_PROT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        prot_q |-> ({match_we, ctrl_we, clr_we} == '0)); // R8

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({match_we, ctrl_we, clr_we})); // R2

endmodule

// File: rtl/cmtimer_pair.sv
module cmtimer_pair
    import cmtimer_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gp_tick,
    input  logic              dbg_tick,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              gp_irq,
    output logic              dbg_irq
);

    localparam int NUM_CH = 2;

    logic [NUM_CH-1:0][DATA_W-1:0] cnt_v;
    logic [NUM_CH-1:0][DATA_W-1:0] match_v;
    logic [NUM_CH-1:0][1:0]        ctrl_v;
    logic [NUM_CH-1:0]             tick_v;
    logic [NUM_CH-1:0]             irq_v;
    logic [NUM_CH-1:0]             mwe_v;
    logic [NUM_CH-1:0]             cwe_v;
    logic [NUM_CH-1:0]             clwe_v;

    assign tick_v = {dbg_tick, gp_tick};

    cmtimer_decode #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .NUM_CH (NUM_CH)
    ) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .prot_wbit (bus_wdata[0]),
        .ch_count  (cnt_v),
        .ch_match  (match_v),
        .ch_ctrl   (ctrl_v),
        .match_we  (mwe_v),
        .ctrl_we   (cwe_v),
        .clr_we    (clwe_v),
        .bus_rdata (bus_rdata)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        cmtimer_chan #(
            .CNT_W  (CNT_W),
            .DATA_W (DATA_W)
        ) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick_v[c]),
            .match_we (mwe_v[c]),
            .ctrl_we  (cwe_v[c]),
            .clr_we   (clwe_v[c]),
            .wdata    (bus_wdata),
            .count_o  (cnt_v[c]),
            .match_o  (match_v[c]),
            .ctrl_o   (ctrl_v[c]),
            .irq_o    (irq_v[c])
        );
    end

    assign gp_irq  = irq_v[0];
    assign dbg_irq = irq_v[1];

    AST_IRQ_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
        gp_irq |-> $past(gp_tick)); // R9

endmodule

// File: tb/sim_cmtimer_pair.sv
module sim_cmtimer_pair;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        gp_tick = 1'b0;
    logic        dbg_tick = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata, rdata1;
    logic        gp_irq, dbg_irq, gp_irq1, dbg_irq1;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cmtimer_pair u0 (
        .clk(clk), .rst_n(rst_n), .gp_tick(gp_tick), .dbg_tick(dbg_tick),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .gp_irq(gp_irq), .dbg_irq(dbg_irq)
    );

    // Narrow-counter copy, used to reach the wrap in a few hundred ticks.
    cmtimer_pair #(.CNT_W(8)) u1 (
        .clk(clk), .rst_n(rst_n), .gp_tick(gp_tick), .dbg_tick(dbg_tick),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(rdata1), .gp_irq(gp_irq1), .dbg_irq(dbg_irq1)
    );

    typedef struct packed {
        logic [5:0]  a;
        logic        w;
        logic [31:0] d;
        logic        gt;
        logic        dt;
        logic [5:0]  ca;
        logic [31:0] ex;
        logic        gi;
        logic        di;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 42;
    localparam vec_t VECS [NV] = '{
        '{6'h00,1'b0,32'h0,1'b0,1'b0,6'h00,32'hFFFF_FFFF,1'b0,1'b0,4'd1}, // R1
        '{6'h00,1'b0,32'h0,1'b0,1'b0,6'h10,32'hFFFF_FFFF,1'b0,1'b0,4'd1}, // R1
        '{6'h00,1'b0,32'h0,1'b0,1'b0,6'h04,32'h0,1'b0,1'b0,4'd1},         // R1
        '{6'h00,1'b0,32'h0,1'b0,1'b0,6'h08,32'h0,1'b0,1'b0,4'd1},         // R1
        '{6'h00,1'b0,32'h0,1'b0,1'b0,6'h20,32'h0,1'b0,1'b0,4'd1},         // R1
        '{6'h00,1'b1,32'h3,1'b0,1'b0,6'h00,32'h3,1'b0,1'b0,4'd2},         // R2 match write
        '{6'h08,1'b1,32'h1,1'b0,1'b0,6'h08,32'h1,1'b0,1'b0,4'd4},         // R4 run
        '{6'h00,1'b0,32'h0,1'b1,1'b0,6'h04,32'h1,1'b0,1'b0,4'd3},         // R3
        '{6'h00,1'b0,32'h0,1'b0,1'b0,6'h04,32'h1,1'b0,1'b0,4'd3},         // R3 no tick
        '{6'h00,1'b0,32'h0,1'b1,1'b0,6'h04,32'h2,1'b0,1'b0,4'd3},         // R3
        '{6'h00,1'b0,32'h0,1'b1,1'b0,6'h04,32'h3,1'b1,1'b0,4'd6},         // R6 match
        '{6'h00,1'b0,32'h0,1'b0,1'b0,6'h04,32'h3,1'b0,1'b0,4'd6},         // R6 one clock
        '{6'h00,1'b0,32'h0,1'b1,1'b0,6'h04,32'h4,1'b0,1'b0,4'd3},         // R3 past match
        '{6'h04,1'b1,32'h55,1'b0,1'b0,6'h04,32'h4,1'b0,1'b0,4'd2},        // R2 count RO
        '{6'h08,1'b1,32'h0,1'b0,1'b0,6'h08,32'h0,1'b0,1'b0,4'd4},         // R4 stop
        '{6'h00,1'b0,32'h0,1'b1,1'b0,6'h04,32'h4,1'b0,1'b0,4'd4},         // R4 hold
        '{6'h0C,1'b1,32'hDEAD,1'b0,1'b0,6'h04,32'h0,1'b0,1'b0,4'd5},      // R5 clear
        '{6'h00,1'b0,32'h0,1'b0,1'b0,6'h0C,32'h0,1'b0,1'b0,4'd2},         // R2 clear reads 0
        '{6'h08,1'b1,32'h3,1'b0,1'b0,6'h08,32'h3,1'b0,1'b0,4'd7},         // R7 reload mode
        '{6'h00,1'b0,32'h0,1'b1,1'b0,6'h04,32'h1,1'b0,1'b0,4'd7},         // R7
        '{6'h00,1'b0,32'h0,1'b1,1'b0,6'h04,32'h2,1'b0,1'b0,4'd7},         // R7
        '{6'h00,1'b0,32'h0,1'b1,1'b0,6'h04,32'h0,1'b1,1'b0,4'd7},         // R7 reload hit
        '{6'h00,1'b0,32'h0,1'b1,1'b0,6'h04,32'h1,1'b0,1'b0,4'd7},         // R7
        '{6'h00,1'b0,32'h0,1'b1,1'b0,6'h04,32'h2,1'b0,1'b0,4'd7},         // R7
        '{6'h0C,1'b1,32'h0,1'b1,1'b0,6'h04,32'h0,1'b0,1'b0,4'd5},         // R5 clear beats tick
        '{6'h10,1'b1,32'h2,1'b0,1'b0,6'h10,32'h2,1'b0,1'b0,4'd9},         // R9
        '{6'h18,1'b1,32'h1,1'b0,1'b0,6'h18,32'h1,1'b0,1'b0,4'd9},         // R9
        '{6'h00,1'b0,32'h0,1'b0,1'b1,6'h14,32'h1,1'b0,1'b0,4'd9},         // R9
        '{6'h00,1'b0,32'h0,1'b0,1'b1,6'h14,32'h2,1'b0,1'b1,4'd9},         // R9 dbg irq only
        '{6'h00,1'b0,32'h0,1'b0,1'b0,6'h04,32'h0,1'b0,1'b0,4'd9},         // R9 gp untouched
        '{6'h20,1'b1,32'h1,1'b0,1'b0,6'h20,32'h1,1'b0,1'b0,4'd8},         // R8 protect on
        '{6'h00,1'b1,32'h7,1'b0,1'b0,6'h00,32'h3,1'b0,1'b0,4'd8},         // R8 match blocked
        '{6'h1C,1'b1,32'h0,1'b0,1'b0,6'h14,32'h2,1'b0,1'b0,4'd8},         // R8 clear blocked
        '{6'h18,1'b1,32'h0,1'b0,1'b0,6'h18,32'h1,1'b0,1'b0,4'd8},         // R8 ctrl blocked
        '{6'h00,1'b0,32'h0,1'b0,1'b1,6'h14,32'h3,1'b0,1'b0,4'd8},         // R8 live read
        '{6'h20,1'b1,32'h0,1'b0,1'b0,6'h20,32'h0,1'b0,1'b0,4'd8},         // R8 protect off
        '{6'h00,1'b1,32'h7,1'b0,1'b0,6'h00,32'h7,1'b0,1'b0,4'd8},         // R8 writes back
        '{6'h00,1'b0,32'h0,1'b0,1'b0,6'h24,32'h0,1'b0,1'b0,4'd2},         // R2 unmapped
        '{6'h08,1'b1,32'h2,1'b0,1'b0,6'h08,32'h2,1'b0,1'b0,4'd4},         // R4 parked readback
        '{6'h00,1'b0,32'h0,1'b1,1'b0,6'h04,32'h0,1'b0,1'b0,4'd4},         // R4 parked holds
        '{6'h20,1'b1,32'h3,1'b0,1'b0,6'h20,32'h1,1'b0,1'b0,4'd2},         // R2 prot bit0 only
        '{6'h20,1'b1,32'h0,1'b0,1'b0,6'h20,32'h0,1'b0,1'b0,4'd2}          // R2
    };

    task automatic chk(input logic [31:0] act, input logic [31:0] exp,
                       input int rq, input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic step(input vec_t v);
        @(negedge clk);
        bus_addr = v.a; bus_wr = v.w; bus_wdata = v.d;
        gp_tick = v.gt; dbg_tick = v.dt;
        @(posedge clk);
        #2;
        bus_wr = 1'b0; gp_tick = 1'b0; dbg_tick = 1'b0; bus_addr = v.ca;
        #1;
        chk(bus_rdata, v.ex, int'(v.rq), "rdata");
        chk({31'b0, gp_irq}, {31'b0, v.gi}, int'(v.rq), "gp_irq");
        chk({31'b0, dbg_irq}, {31'b0, v.di}, int'(v.rq), "dbg_irq");
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R0 watchdog: actual hang expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) step(VECS[i]);

        // R1: reset in the middle of activity
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        bus_addr = 6'h00; #1; chk(bus_rdata, 32'hFFFF_FFFF, 1, "R1 match after reset");
        chk(rdata1, 32'h0000_00FF, 1, "R1 narrow match after reset");
        bus_addr = 6'h14; #1; chk(bus_rdata, 32'h0, 1, "R1 dbg count after reset");
        bus_addr = 6'h18; #1; chk(bus_rdata, 32'h0, 1, "R1 dbg ctrl after reset");
        bus_addr = 6'h20; #1; chk(bus_rdata, 32'h0, 1, "R1 prot after reset");

        // R10: wrap with match 0 on the 8-bit copy
        bus_write(6'h00, 32'h0);
        bus_write(6'h08, 32'h1);
        @(negedge clk);
        gp_tick = 1'b1;
        repeat (255) @(negedge clk);
        gp_tick = 1'b0;
        bus_addr = 6'h04; #1;
        chk(rdata1, 32'hFF, 10, "R10 narrow count before wrap");
        chk({31'b0, gp_irq1}, 32'h0, 10, "R10 no irq before wrap");
        @(negedge clk);
        gp_tick = 1'b1;
        @(posedge clk);
        #2;
        gp_tick = 1'b0;
        #1;
        chk(rdata1, 32'h0, 10, "R10 narrow count wrapped");
        chk({31'b0, gp_irq1}, 32'h1, 10, "R10 irq on wrap");
        chk(bus_rdata, 32'h100, 3, "R3 wide count after 256 ticks");
        chk({31'b0, gp_irq}, 32'h0, 3, "R3 wide no irq");

        finish_run();
    end

endmodule